// File: doc/BRIEF.md
# Five-Function Integer ALU

This block is a purely combinational integer arithmetic logic unit. It takes two operands of a configurable width (32 bits by default) and a 3-bit operation code. It returns a bitwise AND, a bitwise OR, a sum, a difference or a signed set-on-less-than result. It also drives a carry-out flag, a zero flag and a signed-overflow flag. The datapath is a chain of identical one-bit slices with a rippling carry.

Subtraction reuses the same adder. The top bit of the operation code acts as a single negate line: it inverts the second operand in every slice and also feeds the carry into the lowest slice. Set-on-less-than runs that subtraction, takes the sum bit of the top slice, and routes it back into the lowest slice's result. All the higher result bits are driven to zero.

An instruction decoder in the surrounding pipeline drives the operands and the code, and samples the outputs within the same cycle.

Top module: `int_alu5`

## Requirements
- R1: Code 3'b000 drives the result to the bitwise AND of A and B.
- R2: Code 3'b001 drives the result to the bitwise OR of A and B.
- R3: Code 3'b010 drives the result to A+B modulo 2^WIDTH, with carry-out equal to the carry out of the top bit.
- R4: Code 3'b110 drives the result to A+~B+1, which is A-B modulo 2^WIDTH. Carry-out is 1 exactly when A >= B as unsigned numbers.
- R5: Code 3'b111 drives result bit 0 to the top bit of A-B, taken raw with no overflow correction, and drives all higher result bits to 0.
- R6: For the five defined codes, the zero flag is 1 exactly when every result bit is 0.
- R7: For add, overflow is 1 exactly when A and B have the same top bit and the result's top bit differs from it.
- R8: For subtract and set-on-less-than, overflow is 1 exactly when A and B have different top bits and the top bit of A-B differs from A's top bit. For these codes, carry-out follows R4.
- R9: For AND and OR, both carry-out and overflow are 0.
- R10: Codes 3'b011, 3'b100 and 3'b101 produce a result of 0, and carry-out, zero and overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| y_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the top slice |
| zero_o | output | 1 | All result bits are zero (defined codes only) |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The embedded checks assume that the operands and the code are stable, 2-state values, with no unknown bits at any point where the checks evaluate. They place no other limit on the inputs, so every code, including the undefined ones, may appear at any time. The stimulus changes all inputs together once per cycle, a little after the clock edge, and only ever drives known values. The expected set-on-less-than result is computed from the raw sign of the difference. Operand pairs whose difference overflows, such as 0x7FFFFFFF against 0x80000000, are therefore checked against that raw sign and not against a true signed compare.

// File: rtl/int_alu5.sv
module int_alu5 #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] y_o,
  output logic             cout_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic             negate;
  logic             op_ok;
  logic             arith;
  logic [WIDTH-1:0] slice_y;

  assign negate = op_i[2];
  assign op_ok  = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_ADD) ||
                  (op_i == OP_SUB) || (op_i == OP_SLT);
  assign arith  = op_ok & op_i[1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic ci, co, bx, s, less;
    if (i == 0) begin : g_lsb
      assign ci   = negate;
      assign less = g_slice[MSB].s;
    end else begin : g_upper
      assign ci   = g_slice[i-1].co;
      assign less = 1'b0;
    end
    assign bx = b_i[i] ^ negate;
    assign s  = a_i[i] ^ bx ^ ci;
    assign co = (a_i[i] & bx) | (a_i[i] & ci) | (bx & ci);
    assign slice_y[i] = (op_i[1:0] == 2'b00) ? (a_i[i] & bx) :
                        (op_i[1:0] == 2'b01) ? (a_i[i] | bx) :
                        (op_i[1:0] == 2'b10) ? s : less;
  end

  assign y_o    = op_ok ? slice_y : '0;
  assign cout_o = arith & g_slice[MSB].co;
  assign ovf_o  = arith & (g_slice[MSB].co ^ g_slice[MSB].ci);
  assign zero_o = op_ok & ~|y_o;

  always_comb begin
    a_r9_logic_flags: assert (!((op_i == OP_AND || op_i == OP_OR) && (cout_o || ovf_o)))
      else $error("R9 carry or overflow set on a logic code");
    a_r10_bad_op: assert (op_ok || (y_o == '0 && !cout_o && !zero_o && !ovf_o))
      else $error("R10 undefined code produced output");
    a_r5_slt_upper: assert (op_i != OP_SLT || y_o[MSB:1] == '0)
      else $error("R5 upper bits set on set-on-less-than");
    a_r4_sub_carry: assert (op_i != OP_SUB || cout_o == (a_i >= b_i))
      else $error("R4 carry does not match unsigned compare");
    a_r6_zero_eq: assert (!(op_i == OP_SUB && a_i == b_i) || zero_o)
      else $error("R6 equal operands did not give zero");
    a_r6_zero_clear: assert (!zero_o || y_o == '0)
      else $error("R6 zero flag with nonzero result");
    a_r7_add_ovf: assert (op_i != OP_ADD ||
                          ovf_o == ((a_i[MSB] == b_i[MSB]) && (y_o[MSB] != a_i[MSB])))
      else $error("R7 add overflow mismatch");
  end
endmodule

// File: tb/int_alu5_tb.sv
module int_alu5_tb;
  localparam int W = 32;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] y;
    logic         c;
    logic         z;
    logic         v;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [W-1:0] a_i = '0, b_i = '0, y_o;
  logic [2:0] op_i = 3'b000;
  logic cout_o, zero_o, ovf_o;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  int_alu5 #(.WIDTH(W)) u_dut (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .y_o(y_o), .cout_o(cout_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1/R9";
      3'b001: return "R2/R9";
      3'b010: return "R3/R7";
      3'b110: return "R4/R8";
      3'b111: return "R5/R8";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    logic [W:0] sum;
    logic [W-1:0] diff;
    e = '0; e.op = op; e.a = a; e.b = b;
    sum  = {1'b0, a} + {1'b0, b};
    diff = a - b;
    case (op)
      3'b000: e.y = a & b;
      3'b001: e.y = a | b;
      3'b010: begin
        e.y = sum[W-1:0]; e.c = sum[W];
        e.v = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      3'b110, 3'b111: begin
        e.y = (op == 3'b110) ? diff : {{(W-1){1'b0}}, diff[W-1]};
        e.c = (a >= b);
        e.v = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      end
      default: e.y = '0;
    endcase
    e.z = (op inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111}) && (e.y == '0);
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    #1;
    a_i = a; b_i = b; op_i = op;
    q.push_back(model(op, a, b));
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (y_o !== e.y || cout_o !== e.c || zero_o !== e.z || ovf_o !== e.v) begin
        errors++;
        $display("FAIL %s op=%b a=%h b=%h actual y=%h c=%b z=%b v=%b expected y=%h c=%b z=%b v=%b",
                 req_of(e.op), e.op, e.a, e.b, y_o, cout_o, zero_o, ovf_o, e.y, e.c, e.z, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] ops [8];
    ops = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b011, 3'b100, 3'b101};
    repeat (2) @(posedge clk);
    #4;
    checks++;  // reset state: zero inputs, AND code (R1, R6)
    if (y_o !== '0 || zero_o !== 1'b1 || cout_o !== 1'b0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset state actual y=%h z=%b expected y=0 z=1", y_o, zero_o);
    end
    rst_n = 1;
    drive(3'b000, 32'hF0F0_1234, 32'hFF00_FF00);  // R1
    drive(3'b001, 32'hF0F0_1234, 32'h0F00_00C3);  // R2
    drive(3'b001, 32'h0, 32'h0);                  // R2 R6 zero
    drive(3'b010, 32'h0000_0007, 32'h0000_0006);  // R3
    drive(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);  // R3 carry, R6 zero
    drive(3'b010, 32'h4000_0000, 32'h4000_0000);  // R7 overflow
    drive(3'b010, 32'h8000_0000, 32'h8000_0000);  // R7 negative overflow
    drive(3'b110, 32'h0000_0007, 32'h0000_0006);  // R4
    drive(3'b110, 32'h0000_0007, 32'h0000_0008);  // R4 borrow
    drive(3'b110, 32'h1234_5678, 32'h1234_5678);  // R4 R6 equal
    drive(3'b110, 32'h8000_0000, 32'h0000_0001);  // R8 overflow
    drive(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);  // R8 overflow
    drive(3'b111, 32'hFFFF_FFFF, 32'h0000_0001);  // R5 signed less
    drive(3'b111, 32'h0000_0001, 32'hFFFF_FFFF);  // R5 not less
    drive(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);  // R5 raw sign on overflow
    drive(3'b111, 32'h5, 32'h5);                  // R5 R6 equal
    drive(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R10
    drive(3'b100, 32'h1234_5678, 32'h0);          // R10
    drive(3'b101, 32'h0, 32'h0);                  // R10 zero flag cleared
    drive(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R9 logic flags
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = ra;
      drive(ops[i % 8], ra, rb);
    end
    @(posedge clk);
    #6;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule